// File: doc/BRIEF.md
# Legacy Interrupt-Acknowledge Router

This block completes legacy interrupt acknowledges for the CPU. The CPU sends a request that an upstream decoder has already matched to the acknowledge window. That decoder takes no notice of where in the window the access falls, so no offset reaches this block. The router then fetches one byte, the vector number of the interrupting source, from a PIC-style controller. That controller can sit behind either of two back-ends, and a configuration pin `cfg_on_link` selects which one.

With the pin high, the controller is on the packet link. The router then issues a read to a fixed address in the link's special range, FD_F900_0000 through FD_F90F_FFFF, with the compatibility flag set. The controller on the link reports a pending interrupt with an external-interrupt message, and the router shows it on CPU interrupt line 54. With the pin low, the router runs an interrupt-acknowledge cycle on the parallel bus. Either way, the CPU gets back one byte.

All data paths use valid/ready handshakes. A transfer takes place on a rising edge where both valid and ready are high. Once a valid is high, it stays high and its payload stays stable until ready is seen. A receiver may hold ready low for as long as it needs. The back-end response ports and the external-interrupt pin have no ready and are one-cycle pulses.

Top module: `intack_router`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `lnk_req_valid`, `pci_req_valid` and every bit of `irq_lines` are 0.
- R2: Only one acknowledge is outstanding at a time. `cpu_req_ready` is low from the acceptance edge until the CPU has taken the response.
- R3: If `cfg_on_link` is 1 at acceptance, the router raises `lnk_req_valid` with `lnk_req_addr` = 40'hFD_F900_0000 and `lnk_req_compat` = 1. `pci_req_valid` stays 0 for that transaction.
- R4: If `cfg_on_link` is 0 at acceptance, the router raises `pci_req_valid`, and `lnk_req_valid` stays 0 for that transaction.
- R5: `cfg_on_link` is sampled only at acceptance. Changing it during a transaction does not change the back-end that transaction uses.
- R6: The byte returned to the CPU equals the vector on the selected back-end's response, with `cpu_rsp_err` = 0.
- R7: A back-end request stays valid, with a stable address, until that back-end's ready is seen.
- R8: A CPU response stays valid, with a stable vector and error flag, until `cpu_rsp_ready` is seen.
- R9: If no response arrives within TIMEOUT_CYC cycles of acceptance, the CPU response becomes valid exactly TIMEOUT_CYC cycles after the acceptance edge, carrying 8'hFF with `cpu_rsp_err` = 1.
- R10: A back-end response that arrives while no transaction awaits it is ignored and produces no CPU response.
- R11: A pulse on `lnk_extint` sets bit 54 of `irq_lines`, and all other bits stay 0. The bit clears only when a link-path vector is delivered to the CPU without error. A parallel-bus acknowledge leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_on_link | input | 1 | 1: controller on packet link; 0: on parallel bus |
| cpu_req_valid | input | 1 | CPU acknowledge read request |
| cpu_req_ready | output | 1 | Router can accept a request |
| cpu_rsp_valid | output | 1 | Vector byte available |
| cpu_rsp_ready | input | 1 | CPU takes the vector |
| cpu_rsp_vec | output | 8 | Returned vector byte |
| cpu_rsp_err | output | 1 | Response produced by timeout |
| lnk_req_valid | output | 1 | Link read request |
| lnk_req_ready | input | 1 | Link accepts the request |
| lnk_req_addr | output | 40 | Link read address |
| lnk_req_compat | output | 1 | Compatibility flag of the link read |
| lnk_rsp_valid | input | 1 | Link read data pulse |
| lnk_rsp_vec | input | 8 | Link read data byte |
| pci_req_valid | output | 1 | Parallel-bus acknowledge cycle request |
| pci_req_ready | input | 1 | Parallel bus accepts the request |
| pci_rsp_valid | input | 1 | Parallel-bus data pulse |
| pci_rsp_vec | input | 8 | Parallel-bus data byte |
| lnk_extint | input | 1 | External-interrupt message received on link |
| irq_lines | output | 64 | CPU interrupt lines; bit 54 used |

## Verification
The bench flips `cfg_on_link` while a transaction is in flight. A router that reads the pin live would switch back-ends partway through and show a request on the wrong bus. The bench holds back-end ready and CPU ready low for several cycles. A router that drops or changes an unacknowledged payload would lose the vector or corrupt it. The bench counts the exact cycle of the timeout response and then sends a late back-end reply. An off-by-one timer, or a router that accepts replies while idle, would show up as a wrong cycle count or as a spurious second CPU response. Interrupt line 54 is checked across a parallel-bus acknowledge, which must leave it set, and a link acknowledge, which must clear it.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } iack_st_e;

  localparam int LINK_AW = 40;
  localparam logic [LINK_AW-1:0] LINK_IACK_BASE = 40'hFD_F900_0000;
endpackage

// File: rtl/iack_timer.sv
module iack_timer #(
  parameter int TIMEOUT_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);

  // R9: the count never passes the timeout limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/iack_steer.sv
module iack_steer
  import iack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  iack_st_e           st,
  input  logic               path_link,
  output logic               lnk_req_valid,
  input  logic               lnk_req_ready,
  output logic [LINK_AW-1:0] lnk_req_addr,
  output logic               lnk_req_compat,
  input  logic               lnk_rsp_valid,
  input  logic [VEC_W-1:0]   lnk_rsp_vec,
  output logic               pci_req_valid,
  input  logic               pci_req_ready,
  input  logic               pci_rsp_valid,
  input  logic [VEC_W-1:0]   pci_rsp_vec,
  output logic               sel_req_ready,
  output logic               sel_rsp_valid,
  output logic [VEC_W-1:0]   sel_rsp_vec
);
  logic issuing, waiting;

  always_comb begin
    issuing        = (st == ST_ISSUE);
    waiting        = (st == ST_WAIT);
    lnk_req_valid  = issuing &&  path_link;
    pci_req_valid  = issuing && !path_link;
    lnk_req_addr   = LINK_IACK_BASE;
    lnk_req_compat = lnk_req_valid;
    sel_req_ready  = path_link ? lnk_req_ready : pci_req_ready;
    sel_rsp_valid  = waiting && (path_link ? lnk_rsp_valid : pci_rsp_valid);
    sel_rsp_vec    = path_link ? lnk_rsp_vec : pci_rsp_vec;
  end
endmodule

// File: rtl/iack_ctl.sv
module iack_ctl
  import iack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_on_link,
  input  logic             cpu_req_valid,
  output logic             cpu_req_ready,
  output logic             cpu_rsp_valid,
  input  logic             cpu_rsp_ready,
  output logic [VEC_W-1:0] cpu_rsp_vec,
  output logic             cpu_rsp_err,
  output iack_st_e         st,
  output logic             path_link,
  output logic             accept,
  input  logic             sel_req_ready,
  input  logic             sel_rsp_valid,
  input  logic [VEC_W-1:0] sel_rsp_vec,
  input  logic             expire,
  output logic             done_link_ok
);
  localparam logic [VEC_W-1:0] TIMEOUT_VEC = {VEC_W{1'b1}};

  logic [VEC_W-1:0] vec_q;
  logic             err_q;

  assign cpu_req_ready = (st == ST_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cpu_rsp_valid = (st == ST_RESP);
  assign cpu_rsp_vec   = vec_q;
  assign cpu_rsp_err   = err_q;
  assign done_link_ok  = cpu_rsp_valid && cpu_rsp_ready && path_link && !err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      path_link <= 1'b0;
      vec_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st        <= ST_ISSUE;
          path_link <= cfg_on_link;
        end
        ST_ISSUE: if (expire) begin
          st    <= ST_RESP;
          vec_q <= TIMEOUT_VEC;
          err_q <= 1'b1;
        end else if (sel_req_ready) begin
          st <= ST_WAIT;
        end
        ST_WAIT: if (sel_rsp_valid) begin
          st    <= ST_RESP;
          vec_q <= sel_rsp_vec;
          err_q <= 1'b0;
        end else if (expire) begin
          st    <= ST_RESP;
          vec_q <= TIMEOUT_VEC;
          err_q <= 1'b1;
        end
        ST_RESP: if (cpu_rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: the latched path does not move while a transaction is open
  p_path_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !(st == ST_RESP && cpu_rsp_ready)) |=> $stable(path_link));
endmodule

// File: rtl/iack_extint.sv
module iack_extint #(
  parameter int IRQ_COUNT  = 64,
  parameter int EXTINT_IRQ = 54
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg,
  input  logic                 clr,
  output logic [IRQ_COUNT-1:0] irq_lines
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (msg) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  for (genvar i = 0; i < IRQ_COUNT; i++) begin : g_line
    if (i == EXTINT_IRQ) begin : g_used
      assign irq_lines[i] = pend;
    end else begin : g_idle
      assign irq_lines[i] = 1'b0;
    end
  end

  // R11: a message always leaves the line raised on the next cycle
  p_msg_raises_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg |=> irq_lines[EXTINT_IRQ]);
endmodule

// File: rtl/intack_router.sv
module intack_router
  import iack_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int TIMEOUT_CYC = 32,
  parameter int IRQ_COUNT   = 64,
  parameter int EXTINT_IRQ  = 54
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_on_link,
  input  logic                 cpu_req_valid,
  output logic                 cpu_req_ready,
  output logic                 cpu_rsp_valid,
  input  logic                 cpu_rsp_ready,
  output logic [VEC_W-1:0]     cpu_rsp_vec,
  output logic                 cpu_rsp_err,
  output logic                 lnk_req_valid,
  input  logic                 lnk_req_ready,
  output logic [LINK_AW-1:0]   lnk_req_addr,
  output logic                 lnk_req_compat,
  input  logic                 lnk_rsp_valid,
  input  logic [VEC_W-1:0]     lnk_rsp_vec,
  output logic                 pci_req_valid,
  input  logic                 pci_req_ready,
  input  logic                 pci_rsp_valid,
  input  logic [VEC_W-1:0]     pci_rsp_vec,
  input  logic                 lnk_extint,
  output logic [IRQ_COUNT-1:0] irq_lines
);
  iack_st_e         st;
  logic             path_link, accept, expire, done_link_ok;
  logic             sel_req_ready, sel_rsp_valid;
  logic [VEC_W-1:0] sel_rsp_vec;

  iack_ctl #(.VEC_W(VEC_W)) u_ctl (
    .clk, .rst_n, .cfg_on_link, .cpu_req_valid, .cpu_req_ready,
    .cpu_rsp_valid, .cpu_rsp_ready, .cpu_rsp_vec, .cpu_rsp_err,
    .st, .path_link, .accept, .sel_req_ready, .sel_rsp_valid,
    .sel_rsp_vec, .expire, .done_link_ok
  );

  iack_steer #(.VEC_W(VEC_W)) u_steer (
    .st, .path_link, .lnk_req_valid, .lnk_req_ready, .lnk_req_addr,
    .lnk_req_compat, .lnk_rsp_valid, .lnk_rsp_vec, .pci_req_valid,
    .pci_req_ready, .pci_rsp_valid, .pci_rsp_vec, .sel_req_ready,
    .sel_rsp_valid, .sel_rsp_vec
  );

  iack_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk, .rst_n, .start(accept),
    .run(st == ST_ISSUE || st == ST_WAIT), .expire
  );

  iack_extint #(.IRQ_COUNT(IRQ_COUNT), .EXTINT_IRQ(EXTINT_IRQ)) u_extint (
    .clk, .rst_n, .msg(lnk_extint), .clr(done_link_ok), .irq_lines
  );

  // R2: an accepted request blocks further acceptance on the next cycle
  p_single_txn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

  // R3/R4: never both back-ends at once
  p_one_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lnk_req_valid && pci_req_valid));

  // R7: back-end requests hold until taken
  p_lnk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req_valid && !lnk_req_ready && !expire) |=> (lnk_req_valid && $stable(lnk_req_addr)));
  p_pci_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req_valid && !pci_req_ready && !expire) |=> pci_req_valid);

  // R8: CPU response holds under back-pressure
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=>
      (cpu_rsp_valid && $stable(cpu_rsp_vec) && $stable(cpu_rsp_err)));

  // R9: a timeout response carries the all-ones byte
  p_timeout_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_rsp_err) |-> (cpu_rsp_vec == {VEC_W{1'b1}}));
endmodule

// File: tb/sim_intack_router.sv
module sim_intack_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_on_link = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_rsp_ready = 1'b0;
  logic        lnk_req_ready = 1'b0, lnk_rsp_valid = 1'b0;
  logic        pci_req_ready = 1'b0, pci_rsp_valid = 1'b0;
  logic [7:0]  lnk_rsp_vec = 8'h00, pci_rsp_vec = 8'h00;
  logic        lnk_extint = 1'b0;
  logic        cpu_req_ready, cpu_rsp_valid, cpu_rsp_err;
  logic [7:0]  cpu_rsp_vec;
  logic        lnk_req_valid, lnk_req_compat, pci_req_valid;
  logic [39:0] lnk_req_addr;
  logic [63:0] irq_lines;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  intack_router u0 (
    .clk, .rst_n, .cfg_on_link, .cpu_req_valid, .cpu_req_ready,
    .cpu_rsp_valid, .cpu_rsp_ready, .cpu_rsp_vec, .cpu_rsp_err,
    .lnk_req_valid, .lnk_req_ready, .lnk_req_addr, .lnk_req_compat,
    .lnk_rsp_valid, .lnk_rsp_vec, .pci_req_valid, .pci_req_ready,
    .pci_rsp_valid, .pci_rsp_vec, .lnk_extint, .irq_lines
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_issue(input logic on_link);
    @(negedge clk);
    cfg_on_link   = on_link;
    cpu_req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic cpu_take(input logic [7:0] exp_vec, input logic exp_err, input string tag);
    check({tag, " rsp_valid"}, cpu_rsp_valid, 1);
    check({tag, " vec"}, cpu_rsp_vec, exp_vec);
    check({tag, " err"}, cpu_rsp_err, exp_err);
    cpu_rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_rsp_ready = 1'b0;
    check({tag, " R2 ready after take"}, cpu_req_ready, 1);
  endtask

  task automatic t_reset;
    check("R1 req_ready", cpu_req_ready, 1);
    check("R1 rsp_valid", cpu_rsp_valid, 0);
    check("R1 lnk_req", lnk_req_valid, 0);
    check("R1 pci_req", pci_req_valid, 0);
    check("R1 irq", irq_lines, 64'h0);
  endtask

  task automatic t_link_read(input logic [7:0] vec);
    cpu_issue(1'b1);
    check("R2 busy", cpu_req_ready, 0);
    check("R3 lnk_valid", lnk_req_valid, 1);
    check("R3 addr", lnk_req_addr, 40'hFD_F900_0000);
    check("R3 compat", lnk_req_compat, 1);
    check("R3 pci quiet", pci_req_valid, 0);
    repeat (2) @(negedge clk);
    check("R7 lnk held", lnk_req_valid, 1);
    check("R7 addr held", lnk_req_addr, 40'hFD_F900_0000);
    lnk_req_ready = 1'b1;
    @(negedge clk);
    lnk_req_ready = 1'b0;
    check("R7 lnk dropped after take", lnk_req_valid, 0);
    lnk_rsp_valid = 1'b1;
    lnk_rsp_vec   = vec;
    @(negedge clk);
    lnk_rsp_valid = 1'b0;
    lnk_rsp_vec   = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 held valid", cpu_rsp_valid, 1);
    check("R8 held vec", cpu_rsp_vec, vec);
    check("R2 still busy", cpu_req_ready, 0);
    cpu_take(vec, 1'b0, "R6 link");
  endtask

  task automatic t_pci_read_flip(input logic [7:0] vec);
    cpu_issue(1'b0);
    cfg_on_link = 1'b1;
    check("R4 pci_valid", pci_req_valid, 1);
    check("R4 lnk quiet", lnk_req_valid, 0);
    @(negedge clk);
    check("R5 still pci", pci_req_valid, 1);
    check("R5 lnk still quiet", lnk_req_valid, 0);
    pci_req_ready = 1'b1;
    @(negedge clk);
    pci_req_ready = 1'b0;
    lnk_rsp_valid = 1'b1;
    lnk_rsp_vec   = 8'h11;
    @(negedge clk);
    lnk_rsp_valid = 1'b0;
    check("R5 wrong backend ignored", cpu_rsp_valid, 0);
    pci_rsp_valid = 1'b1;
    pci_rsp_vec   = vec;
    @(negedge clk);
    pci_rsp_valid = 1'b0;
    cfg_on_link   = 1'b0;
    cpu_take(vec, 1'b0, "R6 pci");
  endtask

  task automatic t_timeout;
    int n;
    cpu_issue(1'b0);
    n = 0;
    while (!cpu_rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R9 timeout cycle", n, 32);
    cpu_take(8'hFF, 1'b1, "R9 timeout");
    pci_rsp_valid = 1'b1;
    pci_rsp_vec   = 8'h5A;
    @(negedge clk);
    pci_rsp_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 late rsp ignored", cpu_rsp_valid, 0);
    check("R10 still idle", cpu_req_ready, 1);
  endtask

  task automatic t_irq;
    lnk_extint = 1'b1;
    @(negedge clk);
    lnk_extint = 1'b0;
    check("R11 line 54 set", irq_lines, 64'h1 << 54);
    t_pci_read_flip(8'h21);
    check("R11 kept over pci", irq_lines, 64'h1 << 54);
    t_link_read(8'h30);
    check("R11 cleared by link", irq_lines, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_link_read(8'h08);
    t_pci_read_flip(8'hC3);
    t_timeout;
    t_link_read(8'h7E);
    t_irq;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule